// File: doc/BRIEF.md
# Power domain sleep sequencer

This controller sits in an always-on domain and takes one switchable domain into and out of a low-power state. It does this by driving a fixed, ordered set of control outputs. On the way down, the order is: a one-cycle retention save strobe, then isolation enable, then clock gate, then clock/reset parking, and finally power-off. On the way up, the order is: power restored, the power-good acknowledge awaited, a one-cycle retention restore strobe, the clock ungated together with parking released, and finally isolation released.

A sleep request starts the entry. A wake event, such as an interrupt, starts the exit. The step sequence is fixed and does not depend on what the sequencer is attached to. Each step holds for a programmable dwell time before the next step begins.

Status outputs report whether a sequence is in progress, whether the domain is off, and the current step number. These make the control order visible at the ports.

Top module: `pd_sleep_seq`

## Requirements
- R1: An active-low asynchronous reset forces step 0 (active) and drives iso_en, clk_gate, park_en, pwr_off, ret_save, ret_restore, busy and dom_off all to 0, meaning the domain is powered, unclamped and clocked.
- R2: When sleep_req is high while in step 0, the next cycle enters step 1 (save) with ret_save high. The following steps raise one control each: step 2 raises iso_en, step 3 raises clk_gate, step 4 raises park_en and step 5 raises pwr_off. Each of these levels stays high until the exit releases it.
- R3: The step output uses these codes: 0 active, 1 save, 2 isolate, 3 clock gate, 4 park, 5 off, 6 power-up, 7 restore, 8 ungate and unpark, 9 release isolation. A change of step always goes up by one, except that step 9 returns to 0.
- R4: Steps 1, 2, 3, 4, 7, 8 and 9 each last exactly N cycles. N equals the dwell input, or DEF_DWELL (4) when dwell is 0.
- R5: Step 5 lasts at least N cycles. It ends at the first clock edge at which N cycles have elapsed and either wake_evt is high or a wake is pending.
- R6: pwr_off falls on entry to step 6. Step 6 lasts at least N cycles, and it ends only at an edge where pwr_good is sampled high.
- R7: ret_restore is high only in the first cycle of step 7. clk_gate and park_en fall on entry to step 8. iso_en falls on entry to step 9, after all other controls have been released.
- R8: ret_save and ret_restore are single-cycle pulses. There is exactly one of each per sleep/wake round.
- R9: A wake_evt seen during steps 1 to 5 is remembered. The entry still runs to completion, and step 5 then lasts exactly N cycles.
- R10: A wake_evt seen in step 0 or in steps 6 to 9 has no effect and is not remembered.
- R11: A sleep_req seen in steps 6 to 9 is ignored. After the exit, the block stays in step 0 unless sleep_req is high again.
- R12: busy is 1 in steps 1 to 4 and 6 to 9. dom_off is 1 only in step 5. Both are 0 in step 0.
- R13: Whenever pwr_off is high, iso_en, clk_gate and park_en are also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | Request to enter the low-power state, sampled in step 0 |
| wake_evt | input | 1 | Wake event, for example an interrupt |
| pwr_good | input | 1 | Power switch acknowledge that the supply is up |
| dwell | input | CNT_W | Cycles per step; 0 selects DEF_DWELL |
| ret_save | output | 1 | Retention save strobe |
| ret_restore | output | 1 | Retention restore strobe |
| iso_en | output | 1 | Isolation clamp enable |
| clk_gate | output | 1 | Clock gate enable for the switchable domain |
| park_en | output | 1 | Holds clock and reset into the domain non-toggling |
| pwr_off | output | 1 | Power switch off request |
| busy | output | 1 | A sequence step is in progress |
| dom_off | output | 1 | Domain is resting in the off step |
| step | output | 4 | Current step code |

## Verification
All control outputs are decoded from the step register. A wrong step value therefore appears at the ports in the same cycle: a level that does not match the step, or a step code that skips or goes backwards. A wrong dwell count or a wrong wake-pending bit does not show up until the end of the affected step. It appears as a step that lasts the wrong number of cycles, which the bench measures against N, pwr_good timing and wake timing worked out by arithmetic. Across a sweep of dwell values, acknowledge delays and wake positions, every step boundary is checked in the cycle in which it occurs.

// File: rtl/pd_sleep_seq.sv
module pd_sleep_seq #(
  parameter int CNT_W     = 8,
  parameter int DEF_DWELL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_req,
  input  logic             wake_evt,
  input  logic             pwr_good,
  input  logic [CNT_W-1:0] dwell,
  output logic             ret_save,
  output logic             ret_restore,
  output logic             iso_en,
  output logic             clk_gate,
  output logic             park_en,
  output logic             pwr_off,
  output logic             busy,
  output logic             dom_off,
  output logic [3:0]       step
);

  localparam logic [3:0] S_ACT     = 4'd0;
  localparam logic [3:0] S_SAVE    = 4'd1;
  localparam logic [3:0] S_ISO     = 4'd2;
  localparam logic [3:0] S_GATE    = 4'd3;
  localparam logic [3:0] S_PARK    = 4'd4;
  localparam logic [3:0] S_OFF     = 4'd5;
  localparam logic [3:0] S_PWRON   = 4'd6;
  localparam logic [3:0] S_RESTORE = 4'd7;
  localparam logic [3:0] S_UNGATE  = 4'd8;
  localparam logic [3:0] S_UNISO   = 4'd9;
  localparam logic [CNT_W-1:0] DEF_LAST = CNT_W'(DEF_DWELL - 1);

  logic [3:0]       st, st_nx;
  logic [CNT_W-1:0] cnt, last;
  logic             wake_pend, done, in_entry;

  assign last     = (dwell == '0) ? DEF_LAST : dwell - 1'b1;
  assign done     = (cnt == last);
  assign in_entry = (st >= S_SAVE) && (st <= S_OFF);

  always_comb begin
    st_nx = st;
    case (st)
      S_ACT:     if (sleep_req) st_nx = S_SAVE;
      S_SAVE:    if (done) st_nx = S_ISO;
      S_ISO:     if (done) st_nx = S_GATE;
      S_GATE:    if (done) st_nx = S_PARK;
      S_PARK:    if (done) st_nx = S_OFF;
      S_OFF:     if (done && (wake_evt || wake_pend)) st_nx = S_PWRON;
      S_PWRON:   if (done && pwr_good) st_nx = S_RESTORE;
      S_RESTORE: if (done) st_nx = S_UNGATE;
      S_UNGATE:  if (done) st_nx = S_UNISO;
      S_UNISO:   if (done) st_nx = S_ACT;
      default:   st_nx = S_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_ACT;
      cnt       <= '0;
      wake_pend <= 1'b0;
    end else begin
      st <= st_nx;
      if (st_nx != st)
        cnt <= '0;
      else if (!done)
        cnt <= cnt + 1'b1;
      if (st_nx == S_PWRON)
        wake_pend <= 1'b0;
      else if (in_entry && wake_evt)
        wake_pend <= 1'b1;
    end
  end

  assign step        = st;
  assign ret_save    = (st == S_SAVE) && (cnt == '0);
  assign ret_restore = (st == S_RESTORE) && (cnt == '0);
  assign iso_en      = (st >= S_ISO) && (st <= S_UNGATE);
  assign clk_gate    = (st >= S_GATE) && (st <= S_RESTORE);
  assign park_en     = (st >= S_PARK) && (st <= S_RESTORE);
  assign pwr_off     = (st == S_OFF);
  assign busy        = (st != S_ACT) && (st != S_OFF);
  assign dom_off     = (st == S_OFF);

  p_iso_after_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> $past(st) == S_SAVE);
  p_gate_after_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_gate) |-> $past(iso_en));
  p_step_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> (st == (($past(st) == S_UNISO) ? S_ACT : 4'($past(st) + 4'd1))));
  p_wake_needed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_off) |-> $past(wake_evt || wake_pend));
  p_restore_pgood_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ret_restore |-> ($past(pwr_good) && !pwr_off));
  p_iso_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> (!clk_gate && !park_en && !pwr_off));
  p_save_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_save |=> !ret_save);
  p_restore_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_restore |=> !ret_restore);
  p_sleep_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st >= S_PWRON) |=> (st != S_SAVE));
  p_status_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dom_off |-> (!busy && pwr_off));
  p_off_parked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off |-> (iso_en && clk_gate && park_en));

endmodule

// File: tb/test_pd_sleep_seq.sv
module test_pd_sleep_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sleep_req = 1'b0, wake_evt = 1'b0, pwr_good = 1'b1;
  logic [7:0] dwell = 8'd0;
  logic       ret_save, ret_restore, iso_en, clk_gate, park_en, pwr_off, busy, dom_off;
  logic [3:0] step;
  int n_cmp = 0, n_bad = 0;
  bit summary_done = 0;

  pd_sleep_seq i_pd_sleep_seq (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
    .pwr_good(pwr_good), .dwell(dwell), .ret_save(ret_save), .ret_restore(ret_restore),
    .iso_en(iso_en), .clk_gate(clk_gate), .park_en(park_en), .pwr_off(pwr_off),
    .busy(busy), .dom_off(dom_off), .step(step));

  always #5 clk = ~clk;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, "step", step, 0);
    chk(req, "iso/gate/park/off", {iso_en, clk_gate, park_en, pwr_off}, 0);
    chk(req, "save/restore", {ret_save, ret_restore}, 0);
    chk(req, "busy/dom_off", {busy, dom_off}, 0);
  endtask

  task automatic chk_levels(int s, int cis);
    chk("R2", "iso_en", iso_en, (s >= 2 && s <= 8) ? 1 : 0);
    chk("R2", "clk_gate", clk_gate, (s >= 3 && s <= 7) ? 1 : 0);
    chk("R2", "park_en", park_en, (s >= 4 && s <= 7) ? 1 : 0);
    chk("R6", "pwr_off", pwr_off, (s == 5) ? 1 : 0);
    chk("R8", "ret_save", ret_save, (s == 1 && cis == 0) ? 1 : 0);
    chk("R7", "ret_restore", ret_restore, (s == 7 && cis == 0) ? 1 : 0);
    chk("R12", "busy", busy, (s != 0 && s != 5) ? 1 : 0);
    chk("R12", "dom_off", dom_off, (s == 5) ? 1 : 0);
    if (pwr_off) chk("R13", "parked while off", {iso_en, clk_gate, park_en}, 7);
  endtask

  task automatic round(int d, int g, int w, bit mid, bit slx);
    int d1, prev, cis, guard, expd;
    d1 = (d == 0) ? 4 : d;
    dwell = 8'(d);
    @(negedge clk); wake_evt = 1;          // R10: wake in active must be dropped
    @(negedge clk); wake_evt = 0; chk("R10", "active after wake", step, 0);
    sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    prev = -1; cis = 0; guard = 0;
    forever begin
      int s;
      s = step;
      if (prev == -1) begin
        chk("R2", "first step is save", s, 1);
      end else if (s != prev) begin
        if (prev == 5) expd = mid ? d1 : ((w + 1 > d1) ? w + 1 : d1);
        else if (prev == 6) expd = (g + 1 > d1) ? g + 1 : d1;
        else expd = d1;
        chk(prev == 5 ? (mid ? "R9" : "R5") : (prev == 6 ? "R6" : "R4"),
            $sformatf("length of step %0d", prev), cis + 1, expd);
        chk("R3", "step successor", s, (prev == 9) ? 0 : prev + 1);
        cis = 0;
      end else begin
        cis++;
      end
      if (s == 0) break;
      chk_levels(s, cis);
      wake_evt  = (s == 5 && !mid && cis == w) || (s == 2 && mid && cis == 0) ||
                  (s == 7 && cis == 0);       // R10: wake during exit ignored
      pwr_good  = (s == 5) ? 1'b0 : ((s == 6) ? (cis >= g) : 1'b1);
      sleep_req = slx && (s == 7 || s == 9) && cis == 0;
      prev = s;
      guard++;
      if (guard > 400) begin
        chk("R3", "round finished", 0, 1);
        break;
      end
      @(negedge clk);
    end
    wake_evt = 0; sleep_req = 0; pwr_good = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R11", "stays active after exit", step, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1;
    @(negedge clk); chk_idle("R1");
    foreach (int_dw[i]) ;
    for (int di = 0; di < 4; di++)
      for (int gi = 0; gi < 3; gi++)
        for (int wi = 0; wi < 3; wi++)
          for (int m = 0; m < 2; m++) begin
            int dv[4] = '{0, 1, 2, 5};
            int gv[3] = '{0, 3, 7};
            int wv[3] = '{0, 3, 9};
            round(dv[di], gv[gi], wv[wi], m[0], ~m[0]);
          end
    // R1: reset in the middle of the off step
    dwell = 8'd2;
    @(negedge clk); sleep_req = 1;
    @(negedge clk); sleep_req = 0;
    for (int k = 0; k < 60 && step != 4'd5; k++) @(negedge clk);
    chk("R2", "reached off", step, 5);
    #2 rst_n = 0;
    #1 chk_idle("R1");
    @(negedge clk); rst_n = 1;
    @(negedge clk); chk_idle("R1");
    summary();
    $finish;
  end

  int int_dw[1];
endmodule